// File: doc/BRIEF.md
# Serial Divider-Ratio Load Register

This block is the programming port of a dual-modulus frequency synthesizer. A host drives three wires (serial data, serial clock and load enable) and the block turns them into the two counts that the divider chain uses: a 5-bit swallow count A and a 9-bit main count N. The three pins are asynchronous to the block's system clock. Each pin passes through a two-flop synchronizer, and a rising edge of the serial clock is found by comparing the synchronized level with its value one cycle earlier.

On each detected rising edge of the serial clock, the synchronized data bit enters a 14-bit shift register at its low end. While the synchronized load enable is high, a holding latch copies the shift register on every system clock, so the latch is transparent for as long as load enable stays high. When load enable is low, the latch keeps its value. The host sends the main count first, most significant bit first, and the swallow count last. After exactly 14 bits the word is already in place, and no separate framing signal is needed.

Top module: `divratio_serial_load`

## Requirements
- R1: After the active-low asynchronous reset, n_o reads 32 and a_o reads 0.
- R2: Each rising edge of sclk_i shifts exactly one bit, the sdata_i level present at that edge, into a 14-bit shift register.
- R3: The word layout is as follows. The first bit shifted is bit 13 and the last is bit 0. Bits 13..5 give n_o (the first bit is the MSB of n_o) and bits 4..0 give a_o (the last bit is the LSB of a_o).
- R4: While sle_i is high, the outputs follow the shift register, including bits shifted while sle_i stays high.
- R5: While sle_i is low, a_o and n_o keep their value, whatever happens on sdata_i and sclk_i.
- R6: Falling edges of sclk_i and changes of sdata_i while sclk_i is steady shift nothing.
- R7: The outputs take a new value on the third rising edge of clk_i after sle_i goes high, and not before.
- R8: When more than 14 bits are sent, only the last 14 bits decide the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdata_i | input | 1 | Serial data pin |
| sclk_i | input | 1 | Serial clock pin; shifts on its rising edge |
| sle_i | input | 1 | Load enable pin; latch transparent while high |
| a_o | output | 5 | Latched swallow count A |
| n_o | output | 9 | Latched main count N |

## Verification
The bench builds the block with its default parameters: 5-bit A, 9-bit N, a 14-bit frame and two synchronizer stages. With these values, the field split at bit 5 and the three-cycle load latency of the synchronizer become exact, checkable numbers. With the short frame, both the swallow field (0 to 31) and the main field can be tested at their extremes. It is also practical to send overlong frames, and to shift bits while load enable is held high.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
  localparam int unsigned A_W     = 5;
  localparam int unsigned N_W     = 9;
  localparam int unsigned FRAME_W = A_W + N_W;
  localparam int unsigned N_RST   = 32;
  localparam int unsigned SYNC_N  = 2;

  // N occupies the MSB end so a packed cast of the frame splits directly
  typedef struct packed {
    logic [N_W-1:0] n;
    logic [A_W-1:0] a;
  } ratio_t;
endpackage

// File: rtl/dsl_sync.sv
module dsl_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign q_o    = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;

  // R6: an edge pulse never lasts two cycles
  a_r6_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/dsl_shift.sv
module dsl_shift #(
  parameter int unsigned FW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [FW-1:0] word_o
);
  logic [FW-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[FW-2:0], bit_i};
  end

  assign word_o = sr_q;

  a_r2_bit_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (word_o[0] == $past(bit_i)) && (word_o[FW-1:1] == $past(word_o[FW-2:0])));
  a_r6_no_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(word_o));
endmodule

// File: rtl/dsl_latch.sv
module dsl_latch
  import dsl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  ratio_t word_i,
  output ratio_t ratio_o
);
  ratio_t lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q.n <= N_W'(N_RST);
      lat_q.a <= '0;
    end else if (load_i) begin
      lat_q <= word_i;
    end
  end

  assign ratio_o = lat_q;

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(ratio_o));
  a_r4_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ratio_o == $past(word_i));
endmodule

// File: rtl/divratio_serial_load.sv
module divratio_serial_load
  import dsl_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sdata_i,
  input  logic           sclk_i,
  input  logic           sle_i,
  output logic [A_W-1:0] a_o,
  output logic [N_W-1:0] n_o
);
  localparam int unsigned PIN_DATA = 0;
  localparam int unsigned PIN_CLK  = 1;
  localparam int unsigned PIN_LE   = 2;

  logic [2:0]         pin_s, pin_rise;
  logic [FRAME_W-1:0] frame;
  ratio_t             ratio;

  dsl_sync #(.W(3), .STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sle_i, sclk_i, sdata_i}),
    .q_o    (pin_s),
    .rise_o (pin_rise)
  );

  dsl_shift #(.FW(FRAME_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (pin_rise[PIN_CLK]),
    .bit_i   (pin_s[PIN_DATA]),
    .word_o  (frame)
  );

  dsl_latch u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (pin_s[PIN_LE]),
    .word_i  (ratio_t'(frame)),
    .ratio_o (ratio)
  );

  assign a_o = ratio.a;
  assign n_o = ratio.n;

  // R3: the swallow field comes from the last bits shifted
  a_r3_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_s[PIN_LE] |=> (a_o == $past(frame[A_W-1:0])) && (n_o == $past(frame[FRAME_W-1:A_W])));
endmodule

// File: tb/tb_divratio_serial_load.sv
module tb_divratio_serial_load;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sdata = 1'b0, sclk = 1'b0, sle = 1'b0;
  logic [4:0] a_o;
  logic [8:0] n_o;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  divratio_serial_load dut (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .sclk_i(sclk), .sle_i(sle),
    .a_o(a_o), .n_o(n_o)
  );

  // behavioural model: pin history queues, newest first
  bit hd[$], hc[$], hl[$];
  int m_sr, m_lat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd = '{0, 0, 0}; hc = '{0, 0, 0}; hl = '{0, 0, 0};
      m_sr = 0; m_lat = 32 << 5;
    end else begin
      if (hl[1]) m_lat = m_sr;
      if (hc[1] && !hc[2]) m_sr = ((m_sr << 1) | int'(hd[1])) & 16'h3fff;
      hd.push_front(sdata); hc.push_front(sclk); hl.push_front(sle);
      void'(hd.pop_back()); void'(hc.pop_back()); void'(hl.pop_back());
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int outw();
    return (int'(n_o) << 5) | int'(a_o);
  endfunction

  // R4 R5: compare with the model on every clock
  always @(negedge clk) if (rst_n) chk(outw() == m_lat, "R4/R5 model", outw(), m_lat);

  task automatic send_bit(bit b);
    @(negedge clk); sdata = b;
    repeat (2) @(negedge clk); sclk = 1'b1;
    repeat (3) @(negedge clk); sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_word(logic [13:0] w);
    for (int i = 13; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_le();
    @(negedge clk); sle = 1'b1;
    repeat (4) @(negedge clk); sle = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [13:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(n_o == 9'd32, "R1 n", n_o, 32);
    chk(a_o == 5'd0, "R1 a", a_o, 0);

    // R5: a frame without load enable leaves outputs alone
    send_word({9'd300, 5'd17});
    repeat (3) @(negedge clk);
    chk(outw() == (32 << 5), "R5 hold", outw(), 32 << 5);

    // R7: latency of the load
    @(negedge clk); sle = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk(outw() == (32 << 5), "R7 early", outw(), 32 << 5);
    @(posedge clk); #1;
    chk(n_o == 9'd300 && a_o == 5'd17, "R7 R3 loaded", outw(), (300 << 5) | 17);
    @(negedge clk); sle = 1'b0;
    repeat (4) @(negedge clk);

    // R3: field extremes
    send_word({9'd511, 5'd0}); pulse_le();
    chk(n_o == 9'd511 && a_o == 5'd0, "R3 nmax", outw(), 511 << 5);
    send_word({9'd32, 5'd31}); pulse_le();
    chk(n_o == 9'd32 && a_o == 5'd31, "R3 amax", outw(), (32 << 5) | 31);

    // R2 R3: random frames
    for (int k = 0; k < 12; k++) begin
      w = 14'($urandom);
      send_word(w); pulse_le();
      chk(outw() == int'(w), "R2 R3 random", outw(), int'(w));
    end

    // R4: transparency, frame sent while load enable is high
    @(negedge clk); sle = 1'b1;
    send_word({9'd123, 5'd9});
    repeat (3) @(negedge clk);
    chk(outw() == ((123 << 5) | 9), "R4 transparent", outw(), (123 << 5) | 9);
    @(negedge clk); sle = 1'b0;
    repeat (4) @(negedge clk);

    // R8: 20 bits, last 14 count
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_word({9'd64, 5'd5}); pulse_le();
    chk(outw() == ((64 << 5) | 5), "R8 overlong", outw(), (64 << 5) | 5);

    // R6: data toggled while sclk high, then a fall: exactly one shift of '1'
    @(negedge clk); sdata = 1'b1;
    repeat (2) @(negedge clk); sclk = 1'b1;
    repeat (3) @(negedge clk); sdata = 1'b0;
    repeat (3) @(negedge clk); sdata = 1'b1;
    repeat (3) @(negedge clk); sclk = 1'b0;
    repeat (3) @(negedge clk); sdata = 1'b0;
    repeat (3) @(negedge clk);
    pulse_le();
    w = 14'(((64 << 5) | 5) << 1) | 14'd1;
    chk(outw() == int'(w), "R6 one shift", outw(), int'(w));

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule